// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status Queue

This block turns one asynchronous serial input line into a stream of received characters. A clock-enable derived from a divisor input oversamples the line 16 times per bit. The block waits for a start edge and confirms it half a bit later. It then takes 5 to 8 data bits, least significant first, an optional parity bit and one stop bit. The character and three status flags go into a small queue as one unit: a break flag, a framing-error flag and a parity flag. Each flag therefore always describes the character it sits beside.

The consumer watches `rx_ready`. While it is high, the head character and its flags are on the outputs, and a one-cycle `pop` moves to the next entry. If a character completes while the queue is full, it waits in a single holding slot. A second character that completes before space opens replaces the waiting one and raises a sticky overrun flag, which only `clr_err` clears. A break (an all-zero character with a low stop bit) produces exactly one queue entry. After that, framing stops until the line has stayed high for half a bit.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, `rx_ready` and `overrun` are 0.
- R2: `char_len` selects the data length (0 to 5 bits, 1 to 6, 2 to 7, 3 to 8 bits). Bits arrive least significant first, and `rx_data` bits above the length read 0.
- R3: `par_mode` 0 adds a parity bit. With `par_sel` 0 the data and parity bits hold an even number of ones; with `par_sel` 1 an odd number. A mismatch sets the entry's `rx_parity_err`. With `par_mode` 2 there is no parity bit and `rx_parity_err` is 0.
- R4: With `par_mode` 1, the parity bit is expected to equal `par_sel`, and a mismatch sets `rx_parity_err`. With `par_mode` 3, `rx_parity_err` carries the received parity-position bit (the address/data marker).
- R5: The stop bit is sampled once, at its middle. A low level there sets that entry's `rx_frame_err`.
- R6: When the data bits, the parity bit (if any) and the stop bit are all 0, exactly one entry is written, with `rx_break`=1, `rx_frame_err`=1 and data 0. No further entry is written until `rxd` has been high for 8 consecutive oversample ticks.
- R7: A low pulse shorter than half a bit is rejected as a false start, and no entry is written.
- R8: The queue holds `FIFO_DEPTH` (default 4) entries in arrival order. `rx_ready` is high while it holds an entry and stays high until a `pop`. A `pop` while it is empty has no effect.
- R9: A character that completes while the queue is full is held. It enters the queue once a slot frees, behind the older entries.
- R10: If a character completes while another one is held, `overrun` is set. The held character and its status are discarded, and the new one takes its place.
- R11: `overrun` stays set until `clr_err` is pulsed. A new overrun in the same cycle as `clr_err` wins.
- R12: One oversample tick occurs every `baud_div`+1 clock cycles, so one bit lasts 16·(`baud_div`+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| baud_div | input | DIV_W | Oversample divisor; one tick every baud_div+1 cycles |
| char_len | input | 2 | Data length code, 5 + value bits |
| par_mode | input | 2 | 0 normal parity, 1 forced parity, 2 none, 3 address marker |
| par_sel | input | 1 | Odd select (mode 0) or forced level (mode 1) |
| pop | input | 1 | Remove the head entry |
| clr_err | input | 1 | Clear the overrun flag |
| rx_ready | output | 1 | Queue holds at least one entry |
| rx_data | output | 8 | Head character |
| rx_break | output | 1 | Head entry was a break |
| rx_frame_err | output | 1 | Head entry had a low stop bit |
| rx_parity_err | output | 1 | Head entry parity status or address marker |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The properties assume that `clr_err` and `pop` are single-cycle strobes. They also assume that `baud_div`, `char_len` and `par_mode` stay constant while a character is being framed. The bench changes configuration only while the line is idle and the receiver has returned to waiting for a start edge. It drives every strobe for exactly one cycle, on the falling clock edge. The line is driven in whole bit times computed from the current divisor, and break and false-start tests reuse that bit length.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      PAR_NORMAL = 2'b00,
      PAR_FORCED = 2'b01,
      PAR_NONE   = 2'b10,
      PAR_ADDR   = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRKWAIT
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       brk;
      logic       fe;
      logic       pe;
   } rx_entry_t;

endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
   import serial_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] char_len,
   input  logic [1:0] par_mode,
   input  logic       par_sel,
   output logic       done,
   output rx_entry_t  entry
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] LAST_OS = CW'(OVS - 1);
   localparam logic [CW-1:0] MID_OS  = CW'(OVS / 2 - 1);

   rx_state_e   state;
   logic [CW-1:0] os_cnt;
   logic [CW-1:0] hi_cnt;
   logic [2:0]  idx;
   logic [7:0]  shreg;
   logic        par_bit;
   logic        par_en;
   logic [2:0]  last_idx;
   rx_entry_t   nxt;

   assign par_en   = (par_mode != PAR_NONE);
   assign last_idx = 3'd4 + {1'b0, char_len};

   // Status of the frame as seen at the stop-bit sample point.
   always_comb begin
      nxt.data = shreg;
      nxt.fe   = !rxd;
      nxt.brk  = !rxd && (shreg == 8'h00) && !(par_en && par_bit);
      unique case (par_mode)
         PAR_NORMAL: nxt.pe = par_bit ^ (^shreg) ^ par_sel;
         PAR_FORCED: nxt.pe = par_bit ^ par_sel;
         PAR_ADDR:   nxt.pe = par_bit;
         default:    nxt.pe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         os_cnt  <= '0;
         hi_cnt  <= '0;
         idx     <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         done    <= 1'b0;
         entry   <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               ST_IDLE: if (!rxd) begin
                  state  <= ST_START;
                  os_cnt <= '0;
               end
               ST_START: if (os_cnt == MID_OS) begin
                  os_cnt <= '0;
                  if (rxd) state <= ST_IDLE;
                  else begin
                     state   <= ST_DATA;
                     idx     <= '0;
                     shreg   <= '0;
                     par_bit <= 1'b0;
                  end
               end else os_cnt <= os_cnt + 1'b1;
               ST_DATA: if (os_cnt == LAST_OS) begin
                  os_cnt     <= '0;
                  shreg[idx] <= rxd;
                  if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                  else                 idx   <= idx + 1'b1;
               end else os_cnt <= os_cnt + 1'b1;
               ST_PAR: if (os_cnt == LAST_OS) begin
                  os_cnt  <= '0;
                  par_bit <= rxd;
                  state   <= ST_STOP;
               end else os_cnt <= os_cnt + 1'b1;
               ST_STOP: if (os_cnt == LAST_OS) begin
                  os_cnt <= '0;
                  done   <= 1'b1;
                  entry  <= nxt;
                  hi_cnt <= '0;
                  state  <= nxt.brk ? ST_BRKWAIT : ST_IDLE;
               end else os_cnt <= os_cnt + 1'b1;
               ST_BRKWAIT: if (!rxd)            hi_cnt <= '0;
                           else if (hi_cnt == MID_OS) state <= ST_IDLE;
                           else                 hi_cnt <= hi_cnt + 1'b1;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
   import serial_rx_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  rx_entry_t wdata,
   input  logic      pop,
   output rx_entry_t rdata,
   output logic      empty,
   output logic      full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   rx_entry_t      mem [DEPTH];
   logic [PW-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [NW-1:0]  count;
   logic           do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == NW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= wdata;
            wr_ptr      <= wr_nxt;
         end
         if (do_pop) rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
   import serial_rx_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxd,
   input  logic [DIV_W-1:0] baud_div,
   input  logic [1:0]       char_len,
   input  logic [1:0]       par_mode,
   input  logic             par_sel,
   input  logic             pop,
   input  logic             clr_err,
   output logic             rx_ready,
   output logic [7:0]       rx_data,
   output logic             rx_break,
   output logic             rx_frame_err,
   output logic             rx_parity_err,
   output logic             overrun
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic      rxd_s;
   logic      tick;
   logic      frm_done;
   rx_entry_t frm_entry;
   rx_entry_t hold, head, wdata;
   logic      hold_valid;
   logic      push, fifo_empty, fifo_full;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
         end
         assign rxd_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
   );

   serial_rx_deframer #(.OVS(OVS)) u_deframe (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s),
      .char_len(char_len), .par_mode(par_mode), .par_sel(par_sel),
      .done(frm_done), .entry(frm_entry)
   );

   // The held character drains first; a fresh one goes straight in only
   // when nothing is waiting and there is room.
   always_comb begin
      push  = 1'b0;
      wdata = frm_entry;
      if (hold_valid && !fifo_full) begin
         push  = 1'b1;
         wdata = hold;
      end else if (frm_done && !hold_valid && !fifo_full) begin
         push  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold       <= '0;
         hold_valid <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         if (frm_done && (hold_valid || fifo_full)) begin
            hold       <= frm_entry;
            hold_valid <= 1'b1;
         end else if (hold_valid && !fifo_full) begin
            hold_valid <= 1'b0;
         end
         if (frm_done && hold_valid && fifo_full) overrun <= 1'b1;
         else if (clr_err)                        overrun <= 1'b0;
      end
   end

   serial_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(wdata), .pop(pop),
      .rdata(head), .empty(fifo_empty), .full(fifo_full)
   );

   assign rx_ready      = !fifo_empty;
   assign rx_data       = head.data;
   assign rx_break      = head.brk;
   assign rx_frame_err  = head.fe;
   assign rx_parity_err = head.pe;
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pop,
   input logic       clr_err,
   input logic       rx_ready,
   input logic [7:0] rx_data,
   input logic       rx_break,
   input logic       rx_frame_err,
   input logic       overrun,
   input logic       frm_done,
   input logic       hold_valid,
   input logic       fifo_full
);
   // R6
   break_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rx_break) |-> (rx_frame_err && rx_data == 8'h00));

   // R8
   ready_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !pop) |=> rx_ready);

   // R9
   hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !fifo_full && !frm_done) |=> !hold_valid);

   // R10
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && hold_valid && fifo_full) |=> overrun);

   // R11
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr_err) |=> overrun);

   // R11
   overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_err && !(frm_done && hold_valid && fifo_full)) |=> !overrun);
endmodule

bind serial_rx_status serial_rx_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pop(pop), .clr_err(clr_err),
   .rx_ready(rx_ready), .rx_data(rx_data), .rx_break(rx_break),
   .rx_frame_err(rx_frame_err), .overrun(overrun),
   .frm_done(frm_done), .hold_valid(hold_valid), .fifo_full(fifo_full)
);

// File: tb/serial_rx_status_bench.sv
module serial_rx_status_bench;
   localparam int DIV_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rxd = 1'b1;
   logic [DIV_W-1:0] baud_div = '0;
   logic [1:0]       char_len = 2'd3;
   logic [1:0]       par_mode = 2'd2;
   logic             par_sel = 1'b0;
   logic             pop = 1'b0;
   logic             clr_err = 1'b0;
   logic             rx_ready, rx_break, rx_frame_err, rx_parity_err, overrun;
   logic [7:0]       rx_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   serial_rx_status u_serial_rx_status (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
      .char_len(char_len), .par_mode(par_mode), .par_sel(par_sel),
      .pop(pop), .clr_err(clr_err), .rx_ready(rx_ready), .rx_data(rx_data),
      .rx_break(rx_break), .rx_frame_err(rx_frame_err),
      .rx_parity_err(rx_parity_err), .overrun(overrun)
   );

   // {len2, mode2, sel1, flip1, stop1, data8, exp_pe1, exp_fe1}
   localparam int NV = 8;
   localparam logic [16:0] VEC [NV] = '{
      {2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
      {2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0},
      {2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0},
      {2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0},
      {2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
      {2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 8'h96, 1'b1, 1'b0},
      {2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 8'h2A, 1'b1, 1'b0},
      {2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int bit_clks();
      return 16 * (int'(baud_div) + 1);
   endfunction

   task automatic line_bit(input logic v);
      rxd = v;
      wait_clk(bit_clks());
   endtask

   task automatic send_char(input logic [1:0] len, input logic [1:0] mode,
                            input logic sel, input logic flip,
                            input logic stp, input logic [7:0] d);
      int nb;
      logic [7:0] m;
      logic p;
      nb = 5 + int'(len);
      m = d & 8'((1 << nb) - 1);
      char_len = len;
      par_mode = mode;
      par_sel  = sel;
      case (mode)
         2'd0:    p = (^m) ^ sel ^ flip;
         2'd1:    p = sel ^ flip;
         default: p = flip;
      endcase
      line_bit(1'b0);
      for (int i = 0; i < nb; i++) line_bit(d[i]);
      if (mode != 2'd2) line_bit(p);
      line_bit(stp);
      line_bit(1'b1);
      line_bit(1'b1);
   endtask

   task automatic do_pop();
      pop = 1'b1;
      wait_clk(1);
      pop = 1'b0;
      wait_clk(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] exp_d;
      wait_clk(3);
      // R1 reset state
      check("R1 ready", rx_ready, 0);
      check("R1 overrun", overrun, 0);
      rst_n = 1'b1;
      wait_clk(3);
      check("R1 ready after release", rx_ready, 0);

      // Table: R2 lengths, R3 normal parity, R4 forced/address, R5 framing
      for (int v = 0; v < NV; v++) begin
         send_char(VEC[v][16:15], VEC[v][14:13], VEC[v][12], VEC[v][11],
                   VEC[v][10], VEC[v][9:2]);
         exp_d = VEC[v][9:2] & 8'((1 << (5 + int'(VEC[v][16:15]))) - 1);
         check("R8 ready on entry", rx_ready, 1);
         check("R2 data", rx_data, exp_d);
         check("R3/R4 parity status", rx_parity_err, VEC[v][1]);
         check("R5 frame status", rx_frame_err, VEC[v][0]);
         check("R6 no break on data", rx_break, 0);
         do_pop();
         check("R8 empty after pop", rx_ready, 0);
      end

      // R7 false start
      rxd = 1'b0; wait_clk(5); rxd = 1'b1;
      wait_clk(3 * bit_clks());
      check("R7 false start ignored", rx_ready, 0);

      // R6 break: long low, then half-bit-plus high
      char_len = 2'd3; par_mode = 2'd2;
      rxd = 1'b0;
      wait_clk(30 * bit_clks());
      rxd = 1'b1;
      wait_clk(2 * bit_clks());
      check("R6 one entry", rx_ready, 1);
      check("R6 break flag", rx_break, 1);
      check("R6 frame flag", rx_frame_err, 1);
      check("R6 zero data", rx_data, 0);
      do_pop();
      check("R6 only one entry", rx_ready, 0);

      // R8 pop on empty
      do_pop();
      send_char(2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 8'h6E);
      check("R8 pop on empty ignored", rx_data, 8'h6E);
      do_pop();
      check("R8 single entry gone", rx_ready, 0);

      // R9 full queue plus held char
      for (int k = 0; k < 5; k++) send_char(2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 8'(8'h10 + k));
      check("R9 no overrun with one held", overrun, 0);
      for (int k = 0; k < 5; k++) begin
         check("R9 order with held", rx_data, 8'(8'h10 + k));
         do_pop();
      end
      check("R9 drained", rx_ready, 0);

      // R10 overrun discards the waiting one
      for (int k = 0; k < 6; k++) send_char(2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 8'(8'h20 + k));
      check("R10 overrun set", overrun, 1);
      for (int k = 0; k < 4; k++) begin
         check("R10 older entries kept", rx_data, 8'(8'h20 + k));
         do_pop();
      end
      check("R10 newest kept", rx_data, 8'h25);
      do_pop();
      check("R10 waiting char discarded", rx_ready, 0);
      // R11 sticky until clear
      wait_clk(20);
      check("R11 sticky", overrun, 1);
      clr_err = 1'b1; wait_clk(1); clr_err = 1'b0; wait_clk(1);
      check("R11 cleared", overrun, 0);

      // R12 slower divisor
      baud_div = 16'd2;
      wait_clk(10);
      send_char(2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 8'hC3);
      check("R12 data at div 2", rx_data, 8'hC3);
      check("R12 parity at div 2", rx_parity_err, 0);
      do_pop();

      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule